// File: doc/BRIEF.md
# Timer Output-Compare Pin Controller

This block decides, for each of six timer output-compare channels, what level the channel's pin carries and whether the compare logic drives that pin at all. Each channel has a two-bit action code. It is made of one mode bit and one level bit, and it selects what happens to the pin when the channel's comparator reports a match. A force strobe applies the same action without a real match. A per-channel toggle-on-wrap enable inverts the pin whenever the external free-running counter wraps around.

Three small registers hold the configuration: the mode bits, the level bits and the wrap-toggle enables. A plain write/read port with combinational read data gives access to them. Two further inputs come from the surrounding timer. One selects, per channel, whether the channel is an output compare or an input capture. The other is a per-channel output-disconnect bit.

Each channel runs a two-state machine with states PIN_LOW and PIN_HIGH. On every clock edge one of four named transitions is chosen:
- EV_HOLD keeps the state.
- EV_FLIP inverts it.
- EV_CLEAR moves to PIN_LOW.
- EV_SET moves to PIN_HIGH.

A wrap-toggle selects EV_FLIP ahead of any compare action. A match or a force selects the transition named by the action code.

Top module: `oc_pin_ctrl`

## Requirements
- R1: After reset the mode, level and wrap-toggle registers read 0, every `pin_level` bit is 0, every `pin_oe` bit is 0 and every `hit_flag` bit is 0.
- R2: Register addresses are: 0 holds the mode bits, 1 holds the level bits, 2 holds the wrap-toggle enables. In each register, bit i belongs to channel i (bits 5:0). Bits 7:6 of every register and the whole of address 3 read 0, and writes to them are ignored. A write lands at the clock edge on which `bus_wr` is high, and `bus_rdata` shows the addressed register combinationally at any time.
- R3: `pin_oe[i]` is 1 exactly when (mode[i] or level[i]) is 1, `pin_disc[i]` is 0 and `chan_is_oc[i]` is 1. A channel in that condition is called owned.
- R4: On an owned channel, a `cmp_hit[i]` sampled at an edge applies the action {mode,level}: 01 inverts the pin, 10 drives it to 0, 11 drives it to 1. `pin_level[i]` shows the new value right after that edge.
- R5: A `frc_strobe[i]` on an owned channel applies the same action as a match, with the same timing.
- R6: On an owned channel whose wrap-toggle bit is 1, a `cnt_wrap` pulse inverts the pin. With the wrap-toggle bit at 0, `cnt_wrap` has no effect. A channel with `chan_is_oc[i]`=0 is never owned, so it ignores the wrap toggle.
- R7: When a wrap toggle and a forced compare or a match act on the same channel at the same edge, only the inversion takes place and the compare action is dropped.
- R8: While a channel is not owned, its pin state is held: matches, forces and wraps leave `pin_level[i]` unchanged.
- R9: `hit_flag[i]` is 1 for the cycle after an edge at which `cmp_hit[i]` and `chan_is_oc[i]` were both 1, and 0 otherwise. A force strobe never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| cmp_hit | input | 6 | Per-channel comparator match pulse |
| frc_strobe | input | 6 | Per-channel forced-compare strobe |
| cnt_wrap | input | 1 | Counter wrap pulse |
| chan_is_oc | input | 6 | 1 = channel is output compare, 0 = input capture |
| pin_disc | input | 6 | 1 = disconnect compare logic from the pin |
| pin_level | output | 6 | Pin state driven by each channel |
| pin_oe | output | 6 | Output enable of each pin |
| hit_flag | output | 6 | One-cycle compare-flag set pulse |

## Verification
Two functions can act on one channel at the same edge: the wrap toggle and the compare action, which comes from either a real match or a force strobe. The bench provokes this by raising `cnt_wrap` together with `cmp_hit` or `frc_strobe` on the same channel. It does so for every action code, every wrap-enable value and every ownership condition, on each of the six channels. A reference pin level is kept in the bench. It inverts on a wrap when the wrap is enabled and the channel is owned, and otherwise applies the coded action. `pin_level`, `pin_oe` and `hit_flag` are compared against it one edge later.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_t;

    typedef enum logic [1:0] {
        EV_HOLD  = 2'd0,
        EV_FLIP  = 2'd1,
        EV_CLEAR = 2'd2,
        EV_SET   = 2'd3
    } pin_ev_t;

    localparam logic [1:0] REG_MODE  = 2'd0;
    localparam logic [1:0] REG_LEVEL = 2'd1;
    localparam logic [1:0] REG_WRAPT = 2'd2;
endpackage

// File: rtl/oc_regs.sv
module oc_regs #(
    parameter int N_CH = 6,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [N_CH-1:0] mode_q,
    output logic [N_CH-1:0] level_q,
    output logic [N_CH-1:0] wrapt_q
);
    import oc_pkg::*;

    localparam int PAD = DW - N_CH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            level_q <= '0;
            wrapt_q <= '0;
        end else if (wr) begin
            if (addr == AW'(REG_MODE))  mode_q  <= wdata[N_CH-1:0];
            if (addr == AW'(REG_LEVEL)) level_q <= wdata[N_CH-1:0];
            if (addr == AW'(REG_WRAPT)) wrapt_q <= wdata[N_CH-1:0];
        end
    end

    logic [N_CH-1:0] sel_bits;
    always_comb begin
        sel_bits = '0;
        if (addr == AW'(REG_MODE))  sel_bits = mode_q;
        if (addr == AW'(REG_LEVEL)) sel_bits = level_q;
        if (addr == AW'(REG_WRAPT)) sel_bits = wrapt_q;
    end

    generate
        if (PAD > 0) begin : g_pad
            assign rdata = {{PAD{1'b0}}, sel_bits};
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                rdata[DW-1:N_CH] == '0); // R2
        end else begin : g_nopad
            assign rdata = sel_bits[DW-1:0];
        end
    endgenerate

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > AW'(REG_WRAPT)) |-> (rdata == '0)); // R2
endmodule

// File: rtl/oc_chan.sv
module oc_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic level,
    input  logic wrapt,
    input  logic is_oc,
    input  logic disc,
    input  logic hit,
    input  logic frc,
    input  logic wrap,
    output logic pin,
    output logic oe,
    output logic flag
);
    import oc_pkg::*;

    pin_state_t state_q, state_d;
    pin_ev_t    ev;
    logic       owned;
    logic       flag_q;

    assign owned = (mode | level) & ~disc & is_oc;

    // event selection: wrap toggle first, then compare action
    always_comb begin
        ev = EV_HOLD;
        if (owned) begin
            if (wrap && wrapt) begin
                ev = EV_FLIP;
            end else if (hit || frc) begin
                unique case ({mode, level})
                    2'b01:   ev = EV_FLIP;
                    2'b10:   ev = EV_CLEAR;
                    2'b11:   ev = EV_SET;
                    default: ev = EV_HOLD;
                endcase
            end
        end
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            PIN_LOW:  state_d = (ev == EV_FLIP || ev == EV_SET)   ? PIN_HIGH : PIN_LOW;
            PIN_HIGH: state_d = (ev == EV_FLIP || ev == EV_CLEAR) ? PIN_LOW  : PIN_HIGH;
            default:  state_d = PIN_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= hit & is_oc;
        end
    end

    // outputs
    always_comb begin
        pin  = (state_q == PIN_HIGH);
        oe   = owned;
        flag = flag_q;
    end

    AST_WRAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode | level) && !disc && is_oc && wrap && wrapt |=> pin != $past(pin)); // R7
    AST_UNOWNED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> $stable(pin)); // R8
    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        oe && !(wrap && wrapt) && (hit || frc) && mode && level |=> pin); // R4
    AST_CLEAR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        oe && !(wrap && wrapt) && frc && mode && !level |=> !pin); // R5
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frc && !hit |=> !flag); // R9
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl #(
    parameter int N_CH = 6,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_CH-1:0] cmp_hit,
    input  logic [N_CH-1:0] frc_strobe,
    input  logic            cnt_wrap,
    input  logic [N_CH-1:0] chan_is_oc,
    input  logic [N_CH-1:0] pin_disc,
    output logic [N_CH-1:0] pin_level,
    output logic [N_CH-1:0] pin_oe,
    output logic [N_CH-1:0] hit_flag
);
    logic [N_CH-1:0] mode_q, level_q, wrapt_q;

    oc_regs #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .mode_q (mode_q),
        .level_q(level_q),
        .wrapt_q(wrapt_q)
    );

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            oc_chan u_ch (
                .clk  (clk),
                .rst_n(rst_n),
                .mode (mode_q[i]),
                .level(level_q[i]),
                .wrapt(wrapt_q[i]),
                .is_oc(chan_is_oc[i]),
                .disc (pin_disc[i]),
                .hit  (cmp_hit[i]),
                .frc  (frc_strobe[i]),
                .wrap (cnt_wrap),
                .pin  (pin_level[i]),
                .oe   (pin_oe[i]),
                .flag (hit_flag[i])
            );

            AST_OE_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[i] |-> (!pin_disc[i] && chan_is_oc[i] && (mode_q[i] || level_q[i]))); // R3
        end
    endgenerate
endmodule

// File: tb/sim_oc_pin_ctrl.sv
module sim_oc_pin_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] cmp_hit = '0, frc_strobe = '0, chan_is_oc = '0, pin_disc = '0;
    logic       cnt_wrap = 1'b0;
    logic [5:0] pin_level, pin_oe, hit_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [5:0] exp_pin = '0;

    always #5 clk = ~clk;

    oc_pin_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_hit(cmp_hit),
        .frc_strobe(frc_strobe), .cnt_wrap(cnt_wrap), .chan_is_oc(chan_is_oc),
        .pin_disc(pin_disc), .pin_level(pin_level), .pin_oe(pin_oe), .hit_flag(hit_flag)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_level", {2'b0, pin_level}, 8'h00);
        chk("R1 pin_oe",    {2'b0, pin_oe},    8'h00);
        chk("R1 hit_flag",  {2'b0, hit_flag},  8'h00);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), r); chk("R1 reg", r, 8'h00);
        end

        // R2 register map
        wr(2'd0, 8'hFF); rd(2'd0, r); chk("R2 mode bits 7:6 zero", r, 8'h3F);
        wr(2'd1, 8'hA5); rd(2'd1, r); chk("R2 level", r, 8'h25);
        wr(2'd2, 8'h5A); rd(2'd2, r); chk("R2 wraptoggle", r, 8'h1A);
        wr(2'd3, 8'hFF); rd(2'd3, r); chk("R2 addr3 zero", r, 8'h00);
        rd(2'd0, r); chk("R2 addr3 write ignored mode", r, 8'h3F);
        rd(2'd1, r); chk("R2 addr3 write ignored level", r, 8'h25);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // sweep: channel x action code x wrap-enable x is_oc x disc x event pattern
        for (int ch = 0; ch < 6; ch++)
        for (int code = 0; code < 4; code++)
        for (int te = 0; te < 2; te++)
        for (int sel = 0; sel < 2; sel++)
        for (int dc = 0; dc < 2; dc++)
        for (int evp = 0; evp < 5; evp++) begin
            logic m, f, o, own;
            logic [5:0] bit_ch;
            bit_ch = 6'(1) << ch;
            m = (evp == 0) || (evp == 4);
            f = (evp == 1) || (evp == 3);
            o = (evp >= 2);
            wr(2'd0, code[1] ? {2'b0, bit_ch} : 8'h00);
            wr(2'd1, code[0] ? {2'b0, bit_ch} : 8'h00);
            wr(2'd2, te[0]   ? {2'b0, bit_ch} : 8'h00);
            rd(2'd0, r); chk("R2 mode readback", r, code[1] ? {2'b0, bit_ch} : 8'h00);
            chan_is_oc = sel[0] ? 6'h3F : 6'h00;
            pin_disc   = dc[0] ? bit_ch : 6'h00;
            #1;
            own = (code != 0) && sel[0] && !dc[0];
            chk("R3 pin_oe", {2'b0, pin_oe}, own ? {2'b0, bit_ch} : 8'h00);

            cmp_hit    = m ? bit_ch : 6'h00;
            frc_strobe = f ? bit_ch : 6'h00;
            cnt_wrap   = o;
            @(posedge clk); #1;
            cmp_hit = '0; frc_strobe = '0; cnt_wrap = 1'b0;

            if (own) begin
                if (o && te[0]) exp_pin[ch] = ~exp_pin[ch];
                else if (m || f) begin
                    if (code == 1) exp_pin[ch] = ~exp_pin[ch];
                    else if (code == 2) exp_pin[ch] = 1'b0;
                    else if (code == 3) exp_pin[ch] = 1'b1;
                end
            end
            if (!own)
                chk("R8 unowned holds", {2'b0, pin_level}, {2'b0, exp_pin});
            else if (o && (m || f))
                chk("R7 wrap beats compare", {2'b0, pin_level}, {2'b0, exp_pin});
            else if (o)
                chk("R6 wrap toggle", {2'b0, pin_level}, {2'b0, exp_pin});
            else if (f)
                chk("R5 forced action", {2'b0, pin_level}, {2'b0, exp_pin});
            else
                chk("R4 match action", {2'b0, pin_level}, {2'b0, exp_pin});
            chk("R9 hit_flag", {2'b0, hit_flag}, (m && sel[0]) ? {2'b0, bit_ch} : 8'h00);
            @(negedge clk);
        end

        summary();
        $finish;
    end
endmodule